// File: doc/BRIEF.md
# Serial Register Target for a Digital Potentiometer

This block is the two-wire serial target that sits in front of the register controller of a digitally trimmed potentiometer. It runs on a fast system clock and watches clock and data lines that have already been synchronised and filtered. It pulls the data line low through an open-drain enable and never drives it high. A transaction begins with a START condition and an identification byte. That byte must carry a fixed five-bit prefix, then the levels of two address strap pins, then a direction bit. A one-byte register address follows.

A write carries exactly one data byte, which the block hands on through a single-cycle strobe. A read uses the combined form: the master writes the address, issues a repeated START, and sends the identification byte again with the direction bit set. The block then streams bytes from consecutive register locations for as long as the master acknowledges each one. The register controller sees a flat interface made of an address, a write strobe with write data, a read-data input sampled combinationally, and a pulse marking the STOP that closes an addressed transaction.

Top module: `i2c_pot_target`

## Requirements
- R1: After reset the open-drain enable is off, no write strobe is given and no done pulse is given.
- R2: An identification byte whose seven upper bits, sent MSB first, equal 0,1,0,1,0 followed by strap[1] and strap[0] is acknowledged. The block pulls SDA low for the whole ninth clock. The last bit selects the direction: 1 means read and 0 means write.
- R3: An identification byte that does not match is not acknowledged, and the block ignores all following bytes until the next START. It acknowledges none of them and strobes nothing.
- R4: In a write, the address byte and the data byte are each acknowledged. After the eighth data bit, reg_wr pulses high for one cycle while reg_addr holds the address byte and reg_wdata holds the data byte.
- R5: A second data byte in the same write is not acknowledged and gives no strobe.
- R6: In a combined read, each data byte equals reg_rdata for the current reg_addr. Bits are sent MSB first and change only after a falling SCL edge.
- R7: After each byte that is read, the address goes up by one, wrapping from 0xFF to 0x00. Bytes keep coming while the master acknowledges.
- R8: If the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R9: A START that arrives while ready is low is ignored. The block does not acknowledge the identification byte that follows.
- R10: A STOP or START in the middle of a data byte abandons the write with no strobe. The next full transaction then works normally.
- R11: reg_done pulses for one cycle after a STOP that ends a transaction whose identification byte matched. It does not pulse otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ready | input | 1 | Power-up ready; START is ignored while low |
| strap | input | 2 | Address strap pin levels, strap[1] sent first |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (resolved bus level) |
| sda_oe | output | 1 | High pulls SDA low |
| reg_addr | output | 8 | Register address to the controller |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for reg_addr |
| reg_done | output | 1 | One-cycle pulse after an addressed transaction's STOP |

## Verification
A wrong bit count or a wrong state is seen at once on the bus. The acknowledge slot moves, and the master then samples a missing or extra low on the ninth clock of the very byte that went wrong. A wrong address register shows up in the first data byte of a burst as a value that does not match the controller's function of the address, or as a strobe that carries the wrong address. A read pointer that fails to advance or to wrap is seen at the second byte, or at the byte after address 0xFF. The bench runs every strap setting against matching and corrupted prefixes, plus reads that start at the edges of the address space.

// File: rtl/i2c_pot_target.sv
`timescale 1ns/1ps
module i2c_pot_target #(
  parameter logic [4:0] ID_PREFIX = 5'b01010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic [1:0] strap,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  output logic       reg_done
);

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_IDACK, S_ADDR, S_ADDRACK, S_WDATA, S_WACK, S_RDATA, S_RACK, S_IGN
  } st_t;

  st_t        st;
  logic       scl_q, sda_q, rd, mack, matched;
  logic [3:0] cnt;
  logic [7:0] sh;

  logic scl_rise, scl_fall, start_c, stop_c, rx, id_ok;
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  assign rx       = (st == S_ID) || (st == S_ADDR) || (st == S_WDATA);
  assign id_ok    = (sh[7:3] == ID_PREFIX) && (sh[2:1] == strap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      st        <= S_IDLE;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_done  <= 1'b0;
      rd        <= 1'b0;
      mack      <= 1'b0;
      matched   <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
    end else begin
      scl_q    <= scl_i;
      sda_q    <= sda_i;
      reg_wr   <= 1'b0;
      reg_done <= 1'b0;
      if (stop_c) begin
        st       <= S_IDLE;
        sda_oe   <= 1'b0;
        reg_done <= matched;
        matched  <= 1'b0;
      end else if (start_c && ready) begin
        st     <= S_ID;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (rx) begin
          sh  <= {sh[6:0], sda_i};
          cnt <= cnt + 4'd1;
        end
        if (st == S_RACK) mack <= ~sda_i;
      end else if (scl_fall) begin
        case (st)
          S_ID: if (cnt == 4'd8) begin
            if (id_ok) begin
              sda_oe  <= 1'b1;
              rd      <= sh[0];
              matched <= 1'b1;
              st      <= S_IDACK;
            end else st <= S_IGN;
          end
          S_ADDR: if (cnt == 4'd8) begin
            reg_addr <= sh;
            sda_oe   <= 1'b1;
            st       <= S_ADDRACK;
          end
          S_WDATA: if (cnt == 4'd8) begin
            reg_wdata <= sh;
            reg_wr    <= 1'b1;
            sda_oe    <= 1'b1;
            st        <= S_WACK;
          end
          S_IDACK: begin
            cnt <= '0;
            if (rd) begin
              sh     <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              st     <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_ADDR;
            end
          end
          S_ADDRACK: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_WDATA;
          end
          S_WACK: begin
            sda_oe <= 1'b0;
            st     <= S_IGN;
          end
          S_RDATA: if (cnt == 4'd7) begin
            sda_oe   <= 1'b0;
            reg_addr <= reg_addr + 8'd1;
            st       <= S_RACK;
          end else begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
            cnt    <= cnt + 4'd1;
          end
          S_RACK: if (mack) begin
            cnt    <= '0;
            sh     <= reg_rdata;
            sda_oe <= ~reg_rdata[7];
            st     <= S_RDATA;
          end else st <= S_IGN;
          default: ;
        endcase
      end
    end
  end

  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_IGN) |-> !sda_oe);
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_strobe_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (st == S_WACK && sda_oe));
  assert_drive_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_i));
  assert_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && !ready && st == S_IDLE) |=> st == S_IDLE);
  assert_stop_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE && !sda_oe && !reg_wr));
  assert_done_after_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_done |-> $past(stop_c));

endmodule

// File: tb/i2c_pot_target_test.sv
`timescale 1ns/1ps
module i2c_pot_target_test;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ready = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       sda_oe, reg_wr, reg_done;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  logic [7:0] last_a = 8'h00;
  logic [7:0] last_d = 8'h00;

  always #2.5 clk = ~clk;

  assign sda_line  = ~(m_low | sda_oe);
  assign reg_rdata = 8'(reg_addr * 8'd29 + 8'd71);

  i2c_pot_target uut (
    .clk(clk), .rst_n(rst_n), .ready(ready), .strap(strap),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_done(reg_done)
  );

  always @(posedge clk) begin
    if (reg_wr) begin
      wr_cnt <= wr_cnt + 1;
      last_a <= reg_addr;
      last_d <= reg_wdata;
    end
    if (reg_done) done_cnt <= done_cnt + 1;
  end

  function automatic logic [7:0] rfun(input logic [7:0] a);
    return 8'(a * 8'd29 + 8'd71);
  endfunction

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin
      m_low = 1'b0; hold(Q);
      scl = 1'b1; hold(Q);
    end
    m_low = 1'b1; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0;
    m_low = 1'b1; hold(Q);
    scl = 1'b1; hold(Q);
    m_low = 1'b0; hold(2*Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; hold(Q);
    scl = 1'b1; hold(2*Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_low = 1'b0; hold(Q);
    scl = 1'b1; hold(Q);
    ack = ~sda_line; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl = 1'b1; hold(Q);
      b[i] = sda_line; hold(Q);
      scl = 1'b0;
    end
    m_low = give_ack; hold(Q);
    scl = 1'b1; hold(2*Q);
    scl = 1'b0; hold(1);
    m_low = 1'b0; hold(Q-1);
  endtask

  localparam logic [7:0] IDW = 8'h52;
  localparam logic [7:0] IDR = 8'h53;

  initial begin
    logic ack;
    logic [7:0] b;
    int w0, d0;
    logic [7:0] starts [4];
    logic [7:0] waddr [6];
    starts = '{8'h00, 8'h7F, 8'hFD, 8'hFF};
    waddr  = '{8'h00, 8'h01, 8'h55, 8'hAA, 8'hFE, 8'hFF};

    hold(3);
    expect_eq("R1 sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1; hold(4);
    expect_eq("R1 sda_oe after reset", int'(sda_oe), 0);
    expect_eq("R1 reg_wr after reset", int'(reg_wr), 0);
    expect_eq("R1 reg_done after reset", int'(reg_done), 0);

    // R2 R3 R11: identification sweep over every strap setting
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int k = 0; k < 9; k++) begin
        logic [6:0] id7;
        logic exp;
        if (k < 4) id7 = {5'b01010, 2'(k)};
        else id7 = {5'b01010 ^ 5'(1 << (k - 4)), 2'(s)};
        exp = (id7 == {5'b01010, 2'(s)});
        w0 = wr_cnt; d0 = done_cnt;
        bus_start();
        send_byte({id7, 1'b0}, ack);
        expect_eq(exp ? "R2 id ack" : "R3 id nack", int'(ack), int'(exp));
        send_byte(8'(8'h20 + k), ack);
        expect_eq(exp ? "R4 addr ack" : "R3 addr ignored", int'(ack), int'(exp));
        send_byte(8'(8'hC0 + s), ack);
        expect_eq(exp ? "R4 data ack" : "R3 data ignored", int'(ack), int'(exp));
        bus_stop();
        expect_eq("R3 strobe count", wr_cnt - w0, int'(exp));
        expect_eq("R11 done pulse count", done_cnt - d0, int'(exp));
      end
    end

    strap = 2'b01;
    // R4 R5: writes over edge addresses, followed by a second data byte
    for (int i = 0; i < 6; i++) begin
      logic [7:0] dv;
      dv = waddr[i] ^ 8'h5A;
      w0 = wr_cnt;
      bus_start();
      send_byte(IDW, ack);       expect_eq("R2 write id ack", int'(ack), 1);
      send_byte(waddr[i], ack);  expect_eq("R4 addr ack", int'(ack), 1);
      send_byte(dv, ack);        expect_eq("R4 data ack", int'(ack), 1);
      expect_eq("R4 one strobe", wr_cnt - w0, 1);
      expect_eq("R4 strobe addr", int'(last_a), int'(waddr[i]));
      expect_eq("R4 strobe data", int'(last_d), int'(dv));
      send_byte(8'h3C, ack);     expect_eq("R5 extra byte nack", int'(ack), 0);
      bus_stop();
      expect_eq("R5 no extra strobe", wr_cnt - w0, 1);
    end

    // R6 R7 R8: combined reads with bursts of four
    for (int i = 0; i < 4; i++) begin
      w0 = wr_cnt;
      bus_start();
      send_byte(IDW, ack);       expect_eq("R6 id ack", int'(ack), 1);
      send_byte(starts[i], ack); expect_eq("R6 addr ack", int'(ack), 1);
      bus_start();
      send_byte(IDR, ack);       expect_eq("R6 read id ack", int'(ack), 1);
      for (int j = 0; j < 4; j++) begin
        recv_byte(j < 3, b);
        expect_eq(j == 0 ? "R6 read byte" : "R7 sequential byte",
                  int'(b), int'(rfun(8'(starts[i] + j))));
      end
      expect_eq("R8 released after nack", int'(sda_oe), 0);
      recv_byte(1'b0, b);
      expect_eq("R8 nothing driven after nack", int'(b), 255);
      bus_stop();
      expect_eq("R6 read gives no strobe", wr_cnt - w0, 0);
    end

    // R9: not ready
    ready = 1'b0;
    w0 = wr_cnt;
    bus_start();
    send_byte(IDW, ack);  expect_eq("R9 id ignored", int'(ack), 0);
    send_byte(8'h10, ack);
    send_byte(8'h99, ack);
    bus_stop();
    expect_eq("R9 no strobe", wr_cnt - w0, 0);
    ready = 1'b1;

    // R10: STOP and START inside a data byte
    w0 = wr_cnt;
    bus_start();
    send_byte(IDW, ack);  send_byte(8'h33, ack);
    for (int i = 0; i < 4; i++) put_bit(i[0]);
    bus_stop();
    expect_eq("R10 stop mid byte no strobe", wr_cnt - w0, 0);
    bus_start();
    send_byte(IDW, ack);  send_byte(8'h34, ack);
    for (int i = 0; i < 5; i++) put_bit(~i[0]);
    bus_start();
    bus_stop();
    expect_eq("R10 start mid byte no strobe", wr_cnt - w0, 0);
    bus_start();
    send_byte(IDW, ack);  expect_eq("R10 recovery id ack", int'(ack), 1);
    send_byte(8'h35, ack);
    send_byte(8'hE7, ack); expect_eq("R10 recovery data ack", int'(ack), 1);
    bus_stop();
    expect_eq("R10 recovery strobe", wr_cnt - w0, 1);
    expect_eq("R10 recovery addr", int'(last_a), 8'h35);
    expect_eq("R10 recovery data", int'(last_d), 8'hE7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule